// File: doc/BRIEF.md
# Execute-Stage Operand Selection and Flag Register

This block is the execute step of a simple sequential 32-bit processor. It receives the decoded opcode and function field of the current instruction, together with the two register operands and the constant word taken from the instruction. From the opcode it picks the two adder inputs and the ALU function. It then produces the execute result `val_e` in the same cycle. One adder therefore covers several jobs: register arithmetic, effective-address formation for loads and stores, and the stack-pointer step of call, return, push and pop.

A three-bit flag register holds the zero, sign and overflow flags. It loads on the clock edge that closes a cycle carrying an arithmetic/logic instruction. Every other opcode leaves it unchanged. The register file, memory access and branch-condition evaluation sit outside this block.

Opcode values, written in hex on `op_code`: 0 halt, 1 nop, 2 register move, 3 immediate move, 4 store, 5 load, 6 arithmetic/logic, 7 jump, 8 call, 9 return, A push, B pop. Values C to F are unused.

Top module: `exe_stage`

## Requirements
- R1: A synchronous active-low reset sets the flags to zero=1, sign=0, overflow=0. The reset takes priority over a flag load in the same cycle.
- R2: For opcode 2 (register move), `val_e` equals `opnd_a`. For opcode 3 (immediate move), `val_e` equals `imm_c`.
- R3: For opcodes 4 and 5 (store and load), `val_e` equals `opnd_b + imm_c` modulo 2^32, so a negative displacement subtracts.
- R4: For opcodes 8 and A (call and push), `val_e` equals `opnd_b - 4`.
- R5: For opcodes 9 and B (return and pop), `val_e` equals `opnd_b + 4` modulo 2^32.
- R6: For opcode 6, `fn_code` selects the operation:
  - 0 gives `opnd_b + opnd_a`;
  - 1 gives `opnd_b - opnd_a`;
  - 2 gives bitwise AND;
  - 3 gives bitwise XOR;
  - values 4 to 15 behave as 0 (add).
- R7: The flags load only on the clock edge after a cycle with opcode 6. Opcodes 0, 1, 2, 3, 4, 5, 7, 8, 9, A, B and C–F leave all three flags unchanged.
- R8: On a load, the zero flag is set when the 32-bit result is zero. The sign flag takes result bit 31.
- R9: On a load, overflow is two's-complement overflow:
  - add: both operands have the same sign and the result sign differs;
  - subtract: the operand signs differ and the result sign differs from `opnd_b`;
  - AND and XOR: overflow is always 0.
- R10: For opcodes 0, 1, 7 and C–F, `val_e` is 0 whatever `fn_code` and the operands hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_code | input | 4 | Instruction opcode |
| fn_code | input | 4 | Instruction function field |
| opnd_a | input | 32 | First register operand |
| opnd_b | input | 32 | Second register operand |
| imm_c | input | 32 | Constant word from the instruction |
| val_e | output | 32 | Execute result, combinational |
| flag_z | output | 1 | Registered zero flag |
| flag_s | output | 1 | Registered sign flag |
| flag_o | output | 1 | Registered overflow flag |

## Verification
Two things can happen in the same cycle: an arithmetic/logic result appears on `val_e`, and the flag register latches that same result at the closing edge. The scoreboard provokes this by issuing arithmetic operations with results that are zero, negative or overflowing. It then checks `val_e` and the updated flags together, a quarter period after that edge. It also places non-arithmetic opcodes right after an arithmetic one, and asserts reset while an arithmetic opcode is present. In both cases the flags must keep the value the reference model holds.

// File: rtl/exe_pkg.sv
// Package exe_pkg
// Shared opcode values, ALU function and operand-source types, and the
// flag word used by the execute stage. Assumes a 4-bit opcode field.
package exe_pkg;

    localparam logic [3:0] IC_HALT  = 4'h0;
    localparam logic [3:0] IC_NOP   = 4'h1;
    localparam logic [3:0] IC_RRMOV = 4'h2;
    localparam logic [3:0] IC_IRMOV = 4'h3;
    localparam logic [3:0] IC_STORE = 4'h4;
    localparam logic [3:0] IC_LOAD  = 4'h5;
    localparam logic [3:0] IC_ARITH = 4'h6;
    localparam logic [3:0] IC_JUMP  = 4'h7;
    localparam logic [3:0] IC_CALL  = 4'h8;
    localparam logic [3:0] IC_RET   = 4'h9;
    localparam logic [3:0] IC_PUSH  = 4'hA;
    localparam logic [3:0] IC_POP   = 4'hB;

    typedef enum logic [1:0] {FN_ADD, FN_SUB, FN_AND, FN_XOR} alu_fn_e;

    typedef enum logic [2:0] {
        SRC_ZERO, SRC_OPA, SRC_IMM, SRC_STEP_DN, SRC_STEP_UP
    } a_src_e;

    typedef struct packed {
        a_src_e  a_src;
        logic    b_use;
        alu_fn_e fn;
        logic    set_flags;
    } exe_ctl_t;

    typedef struct packed {
        logic zf;
        logic sf;
        logic of;
    } flags_t;

    localparam flags_t FLAGS_INIT = '{zf: 1'b1, sf: 1'b0, of: 1'b0};

endpackage

// File: rtl/exe_decode.sv
// Module exe_decode
// Maps opcode and function field onto operand sources, ALU function and
// the flag-load enable. Pure combinational; unknown opcodes do no work.
module exe_decode
    import exe_pkg::*;
(
    input  logic [3:0] op_code,
    input  logic [3:0] fn_code,
    output exe_ctl_t   ctl
);

    // Choose operand sources and ALU function per opcode
    always_comb begin
        ctl = '{a_src: SRC_ZERO, b_use: 1'b0, fn: FN_ADD, set_flags: 1'b0};
        case (op_code)
            IC_RRMOV: ctl.a_src = SRC_OPA;
            IC_IRMOV: ctl.a_src = SRC_IMM;
            IC_STORE, IC_LOAD: begin
                ctl.a_src = SRC_IMM;
                ctl.b_use = 1'b1;
            end
            IC_CALL, IC_PUSH: begin
                ctl.a_src = SRC_STEP_DN;
                ctl.b_use = 1'b1;
            end
            IC_RET, IC_POP: begin
                ctl.a_src = SRC_STEP_UP;
                ctl.b_use = 1'b1;
            end
            IC_ARITH: begin
                ctl.a_src     = SRC_OPA;
                ctl.b_use     = 1'b1;
                ctl.set_flags = 1'b1;
                ctl.fn        = (fn_code[3:2] == 2'b00) ? alu_fn_e'(fn_code[1:0]) : FN_ADD;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/exe_operand_mux.sv
// Module exe_operand_mux
// Builds the two ALU inputs from the selected sources. The stack step is
// a parameter; the B input is either the second operand or zero.
module exe_operand_mux
    import exe_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int STEP = 4
) (
    input  exe_ctl_t          ctl,
    input  logic [XLEN-1:0]   opnd_a,
    input  logic [XLEN-1:0]   opnd_b,
    input  logic [XLEN-1:0]   imm_c,
    output logic [XLEN-1:0]   alu_a,
    output logic [XLEN-1:0]   alu_b
);

    localparam logic [XLEN-1:0] STEP_UP = XLEN'(STEP);
    localparam logic [XLEN-1:0] STEP_DN = '0 - STEP_UP;

    // Select ALU input A
    always_comb begin
        case (ctl.a_src)
            SRC_OPA:     alu_a = opnd_a;
            SRC_IMM:     alu_a = imm_c;
            SRC_STEP_DN: alu_a = STEP_DN;
            SRC_STEP_UP: alu_a = STEP_UP;
            default:     alu_a = '0;
        endcase
    end

    // Select ALU input B
    always_comb alu_b = ctl.b_use ? opnd_b : '0;

endmodule

// File: rtl/exe_alu.sv
// Module exe_alu
// Computes B op A and the candidate flags. Subtract is B - A. Overflow is
// only meaningful for add and subtract and is zero for logic functions.
module exe_alu
    import exe_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_fn_e          fn,
    input  logic [XLEN-1:0]  alu_a,
    input  logic [XLEN-1:0]  alu_b,
    output logic [XLEN-1:0]  result,
    output flags_t           flags
);

    localparam int MSB = XLEN - 1;

    // Perform the selected operation
    always_comb begin
        case (fn)
            FN_SUB:  result = alu_b - alu_a;
            FN_AND:  result = alu_b & alu_a;
            FN_XOR:  result = alu_b ^ alu_a;
            default: result = alu_b + alu_a;
        endcase
    end

    // Derive zero, sign and signed-overflow flags from the result
    always_comb begin
        flags.zf = (result == '0);
        flags.sf = result[MSB];
        case (fn)
            FN_ADD:  flags.of = (alu_a[MSB] == alu_b[MSB]) && (result[MSB] != alu_a[MSB]);
            FN_SUB:  flags.of = (alu_a[MSB] != alu_b[MSB]) && (result[MSB] != alu_b[MSB]);
            default: flags.of = 1'b0;
        endcase
    end

endmodule

// File: rtl/exe_flag_reg.sv
// Module exe_flag_reg
// Three-bit flag register with synchronous active-low reset and a load
// enable. Reset wins over load.
module exe_flag_reg
    import exe_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load,
    input  flags_t d,
    output flags_t q
);

    // Hold or load the flags
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= FLAGS_INIT;
        else if (load) q <= d;
    end

    // R1: reset value appears after a reset edge
    a_r1_reset_value: assert property (@(posedge clk) !rst_n |=> (q == FLAGS_INIT));

    // R7: flags keep their value when no load is requested
    a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));

endmodule

// File: rtl/exe_stage.sv
// Module exe_stage
// Execute stage: decodes the opcode into operand sources, runs the shared
// adder/logic unit and registers the flags for arithmetic/logic opcodes.
// Assumes inputs are stable for the whole cycle; val_e is combinational.
module exe_stage
    import exe_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int STEP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      op_code,
    input  logic [3:0]      fn_code,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    input  logic [XLEN-1:0] imm_c,
    output logic [XLEN-1:0] val_e,
    output logic            flag_z,
    output logic            flag_s,
    output logic            flag_o
);

    localparam logic [XLEN-1:0] STEP_W = XLEN'(STEP);

    exe_ctl_t        ctl;
    logic [XLEN-1:0] alu_a;
    logic [XLEN-1:0] alu_b;
    flags_t          nxt_flags;
    flags_t          cur_flags;

    exe_decode u_decode (
        .op_code (op_code),
        .fn_code (fn_code),
        .ctl     (ctl)
    );

    exe_operand_mux #(.XLEN(XLEN), .STEP(STEP)) u_mux (
        .ctl    (ctl),
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .imm_c  (imm_c),
        .alu_a  (alu_a),
        .alu_b  (alu_b)
    );

    exe_alu #(.XLEN(XLEN)) u_alu (
        .fn     (ctl.fn),
        .alu_a  (alu_a),
        .alu_b  (alu_b),
        .result (val_e),
        .flags  (nxt_flags)
    );

    exe_flag_reg u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ctl.set_flags),
        .d     (nxt_flags),
        .q     (cur_flags)
    );

    // Expose the flag fields as separate ports
    always_comb begin
        flag_z = cur_flags.zf;
        flag_s = cur_flags.sf;
        flag_o = cur_flags.of;
    end

    // R4: call and push step the stack pointer down
    a_r4_stack_down: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == IC_CALL || op_code == IC_PUSH) |-> (val_e == opnd_b - STEP_W));

    // R5: return and pop step the stack pointer up
    a_r5_stack_up: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == IC_RET || op_code == IC_POP) |-> (val_e == opnd_b + STEP_W));

    // R7: non-arithmetic opcodes leave the flag ports unchanged
    a_r7_ports_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code != IC_ARITH) |=> $stable({flag_z, flag_s, flag_o}));

    // R8: after an arithmetic cycle the zero flag reflects that result
    a_r8_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == IC_ARITH) |=> (flag_z == ($past(val_e) == '0)));

    // R9: logic functions never raise overflow
    a_r9_logic_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == IC_ARITH && (fn_code == 4'd2 || fn_code == 4'd3)) |=> !flag_o);

    // R10: idle opcodes produce a zero result
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == IC_HALT || op_code == IC_NOP || op_code == IC_JUMP || op_code >= 4'hC)
        |-> (val_e == '0));

endmodule

// File: tb/exe_stage_tb.sv
// Scoreboard bench for exe_stage: the driver applies one instruction per
// cycle at the falling edge and queues the expected result and flags; the
// monitor compares them a quarter period after the following rising edge.
module exe_stage_tb_top;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [31:0] exp_e;
        logic [2:0]  exp_f;
        string       etag;
        string       ftag;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_code = 4'h1;
    logic [3:0]  fn_code = 4'h0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] imm_c = '0;
    logic [31:0] val_e;
    logic        flag_z, flag_s, flag_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;
    logic [2:0] m_flags = 3'b100;
    sb_item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    exe_stage dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_code (op_code),
        .fn_code (fn_code),
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .imm_c   (imm_c),
        .val_e   (val_e),
        .flag_z  (flag_z),
        .flag_s  (flag_s),
        .flag_o  (flag_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference result from the requirements (R2 to R6, R10)
    function automatic logic [31:0] ref_e(input logic [3:0] ic, input logic [3:0] fc,
                                          input logic [31:0] a, input logic [31:0] b,
                                          input logic [31:0] c);
        case (ic)
            4'h2:       return a;
            4'h3:       return c;
            4'h4, 4'h5: return b + c;
            4'h8, 4'hA: return b - 32'd4;
            4'h9, 4'hB: return b + 32'd4;
            4'h6: case (fc)
                4'd1:    return b - a;
                4'd2:    return b & a;
                4'd3:    return b ^ a;
                default: return b + a;
            endcase
            default:    return 32'h0;
        endcase
    endfunction

    task automatic drive(input logic [3:0] ic, input logic [3:0] fc, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] c,
                         input string etag, input string ftag);
        sb_item_t it;
        logic [31:0] r;
        logic ov;
        @(negedge clk);
        op_code = ic; fn_code = fc; opnd_a = a; opnd_b = b; imm_c = c;
        r = ref_e(ic, fc, a, b, c);
        if (ic == 4'h6) begin
            ov = 1'b0;
            if (fc == 4'd1)
                ov = (a[31] != b[31]) && (r[31] != b[31]);
            else if (fc != 4'd2 && fc != 4'd3)
                ov = (a[31] == b[31]) && (r[31] != a[31]);
            m_flags = {(r == 32'h0), r[31], ov};
        end
        it.exp_e = r; it.exp_f = m_flags; it.etag = etag; it.ftag = ftag;
        sb_q.push_back(it);
    endtask

    // Monitor: compare queued expectations after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                check(it.etag, val_e, it.exp_e);
                check(it.ftag, {29'h0, flag_z, flag_s, flag_o}, {29'h0, it.exp_f});
            end
        end
    end

    // Stimulus
    initial begin
        repeat (3) @(negedge clk);
        @(posedge clk); #(CLK_PERIOD/4);
        check("R1 reset flags", {29'h0, flag_z, flag_s, flag_o}, 32'h4);
        // R1: reset must win over an arithmetic load in the same cycle
        @(negedge clk);
        op_code = 4'h6; fn_code = 4'd0; opnd_a = 32'h8000_0000; opnd_b = 32'h8000_0000;
        @(posedge clk); #(CLK_PERIOD/4);
        check("R1 reset priority", {29'h0, flag_z, flag_s, flag_o}, 32'h4);
        @(negedge clk);
        op_code = 4'h1;
        rst_n = 1'b1;

        drive(4'h2, 4'h0, 32'h1234_5678, 32'hFFFF_0000, 32'h0, "R2 rrmove", "R7 rrmove");
        drive(4'h3, 4'h5, 32'h1, 32'h2, 32'hCAFE_F00D, "R2 irmove", "R7 irmove");
        drive(4'h4, 4'h0, 32'h0, 32'h0000_1000, 32'hFFFF_FFF8, "R3 store", "R7 store");
        drive(4'h5, 4'h0, 32'h0, 32'h0000_0100, 32'h0000_0024, "R3 load", "R7 load");
        drive(4'h8, 4'h0, 32'h0, 32'h0000_0200, 32'h0000_0040, "R4 call", "R7 call");
        drive(4'hA, 4'h0, 32'h5, 32'h0000_0000, 32'h0, "R4 push wrap", "R7 push");
        drive(4'h9, 4'h0, 32'h0, 32'h0000_01FC, 32'h0, "R5 ret", "R7 ret");
        drive(4'hB, 4'h0, 32'h0, 32'hFFFF_FFFC, 32'h0, "R5 pop wrap", "R7 pop");
        drive(4'h6, 4'd0, 32'h7FFF_FFFF, 32'h0000_0001, 32'h0, "R6 add", "R9 add overflow");
        drive(4'h7, 4'd3, 32'h1, 32'h1, 32'h1, "R10 jump", "R7 jump keeps flags");
        drive(4'h6, 4'd1, 32'h0000_0001, 32'h8000_0000, 32'h0, "R6 sub", "R9 sub overflow");
        drive(4'h6, 4'd1, 32'h0000_0033, 32'h0000_0033, 32'h0, "R6 sub zero", "R8 zero flag");
        drive(4'h0, 4'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h1, "R10 halt", "R7 halt keeps flags");
        drive(4'h6, 4'd2, 32'hF0F0_F0F0, 32'h8F0F_FFFF, 32'h0, "R6 and", "R8 sign flag");
        drive(4'h6, 4'd3, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0, "R6 xor", "R9 xor no overflow");
        drive(4'hD, 4'd6, 32'h3, 32'h4, 32'h5, "R10 unused opcode", "R7 unused keeps flags");
        drive(4'h6, 4'd9, 32'h0000_0010, 32'h0000_0020, 32'h0, "R6 high fn as add", "R8 high fn");
        drive(4'h6, 4'd0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0, "R6 add to zero", "R8 carry out zero");
        drive(4'h1, 4'd0, 32'h0, 32'h0, 32'h0, "R10 nop", "R7 nop keeps flags");
        drive(4'h6, 4'd0, 32'h8000_0000, 32'h8000_0000, 32'h0, "R6 add negatives", "R9 neg overflow");
        drive(4'h3, 4'd0, 32'h0, 32'h0, 32'h0, "R2 irmove zero", "R7 irmove keeps flags");
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule